// File: doc/BRIEF.md
# Shortened Reed-Solomon Parity and Syndrome Engine

This block sits beside a byte-wide memory path and protects 512-byte blocks with a distance-5 Reed-Solomon code over GF(2^10). The code is shortened so that a block holds 512 data symbols and 4 check symbols, 516 symbols in all. Storage is 8 bits wide, so each data byte becomes a 10-bit symbol by taking two zero bits on top. Each 10-bit check word is stored as two bytes. The stored block is therefore 520 bytes long.

In write mode the host streams the 512 data bytes through the block. The parity words are updated one symbol per strobe. Right after the last data byte, the block drives the eight parity bytes on its parity output, one per further strobe, so they can be written behind the data. In read mode the host streams all 520 stored bytes. The block rebuilds each 10-bit check word from its two bytes and evaluates four syndromes. When the last byte has been taken, the syndromes and a nonzero flag are ready. Locating and fixing errors is left to the host.

Top module: `rsx_parsyn_engine`

## Requirements
- R1: After reset, `syn_word` is zero, `syn_flag` is low, `par_byte` is zero, and the byte position is at the start of a block.
- R2: A data byte (positions 0..511) enters both the encoder and the syndrome logic as a 10-bit symbol with bits 9:8 zero and bits 7:0 equal to the byte.
- R3: The parity words P3..P0 are the coefficients of the remainder of d(x)*x^4 divided by g(x). Here d(x) has the first data byte as its highest-degree term, g(x) = (x+a^0)(x+a^1)(x+a^2)(x+a^3), and a is a root of the field polynomial x^10+x^3+1. The bytes are presented in the order P3 low, P3 high, P2 low, P2 high, P1 low, P1 high, P0 low, P0 high. A low byte is word bits 7:0. A high byte is {6'b0, word bits 9:8}.
- R4: The first parity byte is on `par_byte` in the cycle right after the clock edge that takes the 512th data byte in write mode. Each further strobe advances to the next byte. `par_byte` is zero outside these eight positions.
- R5: Strobes during the parity positions do not change the parity words. Their byte values are ignored, and all eight parity bytes read out unchanged.
- R6: In read mode, syndrome S_k (k = 0..3) equals the sum over j of r_j*a^(k*(515-j)). Here r_j is symbol j of the received block and S_k is on `syn_word[10k+9:10k]`. For a check word w = 0..3, the symbol r_(512+w) is {bits 1:0 of byte 513+2w, byte 512+2w}.
- R7: `syn_flag` is high exactly when at least one syndrome is nonzero. A block written by this engine and read back unaltered gives all-zero syndromes.
- R8: The syndromes are final in the cycle after the edge that takes the 520th byte. Strobes beyond byte 520 change nothing until a clear.
- R9: `clr_par` zeroes the parity words and `clr_syn` zeroes the syndromes. Either clear moves the byte position back to the start of a block.
- R10: Cycles with `in_valid` low change neither parity, syndromes nor byte position, whatever `in_byte` holds.
- R11: On read, bits 7:2 of the stored high byte of each check word are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_par | input | 1 | Clear parity words and byte position |
| clr_syn | input | 1 | Clear syndromes and byte position |
| in_valid | input | 1 | Byte strobe |
| in_mode | input | 1 | 0 = write (encode), 1 = read (check) |
| in_byte | input | 8 | Byte from the memory path |
| par_byte | output | 8 | Parity byte to store during the parity positions |
| syn_word | output | 40 | Four 10-bit syndromes, S0 in bits 9:0 |
| syn_flag | output | 1 | High when any syndrome is nonzero |

## Verification
The bench checks the outputs against values computed its own way. It uses log and antilog tables, long division for the parity, and direct power sums for the syndromes. A wrong tap or a wrong feedback constant in the encoder shows up within the same block as a wrong parity byte. It also shows up as a nonzero syndrome when the stored block is read back clean. A slip in byte position or in parity repacking shows up at the first parity byte, or when the syndromes are read after byte 520. Error blocks with faults in data, in check-word low bytes, and in the significant and insignificant bits of the high bytes separate the repacking paths from one another.

// File: rtl/rsx_pkg.sv
package rsx_pkg;

    localparam int SYM_W       = 10;
    localparam int BYTE_W      = 8;
    localparam int NROOTS      = 4;
    localparam int DATA_SYMS   = 512;
    localparam int PAR_BYTES   = NROOTS * 2;
    localparam int BLOCK_BYTES = DATA_SYMS + PAR_BYTES;
    localparam int CNT_W       = $clog2(BLOCK_BYTES + 1);
    localparam int SEL_W       = $clog2(PAR_BYTES);
    localparam int PAD_W       = SYM_W - BYTE_W;

    // x^10 + x^3 + 1
    localparam logic [SYM_W:0] FIELD_POLY = 11'h409;

    typedef logic [SYM_W-1:0]  sym_t;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef sym_t [NROOTS-1:0] symvec_t;
    typedef sym_t [NROOTS:0]   genpoly_t;

    typedef enum logic {MODE_WRITE = 1'b0, MODE_READ = 1'b1} mode_e;

    typedef struct packed {
        logic en;
        sym_t sym;
    } sym_beat_t;

    function automatic sym_t gf_mul(sym_t a, sym_t b);
        sym_t acc;
        sym_t sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < SYM_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            if (sh[SYM_W-1]) sh = {sh[SYM_W-2:0], 1'b0} ^ FIELD_POLY[SYM_W-1:0];
            else             sh = {sh[SYM_W-2:0], 1'b0};
        end
        return acc;
    endfunction

    function automatic sym_t alpha_pow(int k);
        sym_t r;
        r = sym_t'(1);
        for (int i = 0; i < k; i++) r = gf_mul(r, sym_t'(2));
        return r;
    endfunction

    // product of (x + a^j), j = 0..NROOTS-1; index = degree
    function automatic genpoly_t gen_poly();
        genpoly_t g;
        sym_t     root;
        g    = '0;
        g[0] = sym_t'(1);
        for (int j = 0; j < NROOTS; j++) begin
            root = alpha_pow(j);
            for (int d = NROOTS; d >= 1; d--) g[d] = g[d-1] ^ gf_mul(g[d], root);
            g[0] = gf_mul(g[0], root);
        end
        return g;
    endfunction

endpackage

// File: rtl/rsx_byte_sequencer.sv
module rsx_byte_sequencer
    import rsx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             in_valid,
    input  mode_e            mode,
    input  byte_t            in_byte,
    output sym_beat_t        enc_beat,
    output sym_beat_t        chk_beat,
    output logic             par_phase,
    output logic [SEL_W-1:0] par_sel
);
    localparam logic [CNT_W-1:0] DATA_END  = CNT_W'(DATA_SYMS);
    localparam logic [CNT_W-1:0] BLOCK_END = CNT_W'(BLOCK_BYTES);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] off;
    byte_t            lo_hold_q;
    logic             in_data, in_par, take;

    assign in_data = cnt_q < DATA_END;
    assign in_par  = !in_data && (cnt_q < BLOCK_END);
    assign take    = in_valid && (cnt_q < BLOCK_END);
    assign off     = cnt_q - DATA_END;

    always_ff @(posedge clk) begin
        if (rst || clr)  cnt_q <= '0;
        else if (take)   cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)                             lo_hold_q <= '0;
        else if (take && in_par && !off[0])  lo_hold_q <= in_byte;
    end

    always_comb begin
        enc_beat.en  = take && in_data && (mode == MODE_WRITE);
        enc_beat.sym = {{PAD_W{1'b0}}, in_byte};
        chk_beat.en  = take && (mode == MODE_READ) && (in_data || off[0]);
        chk_beat.sym = in_data ? {{PAD_W{1'b0}}, in_byte}
                               : {in_byte[PAD_W-1:0], lo_hold_q};
    end

    assign par_phase = in_par && (mode == MODE_WRITE);
    assign par_sel   = off[SEL_W-1:0];

    // R8
    cnt_limit_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == BLOCK_END && !clr) |=> (cnt_q == BLOCK_END));

    // R10
    cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/rsx_parity_lfsr.sv
module rsx_parity_lfsr
    import rsx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  sym_beat_t beat,
    output symvec_t   par
);
    localparam genpoly_t GEN = gen_poly();

    symvec_t par_q;
    symvec_t par_d;
    sym_t    fb;

    assign fb = beat.sym ^ par_q[NROOTS-1];

    generate
        for (genvar i = 0; i < NROOTS; i++) begin : g_tap
            if (i == 0) begin : g_low
                assign par_d[i] = gf_mul(fb, GEN[i]);
            end else begin : g_mid
                assign par_d[i] = par_q[i-1] ^ gf_mul(fb, GEN[i]);
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || clr)    par_q <= '0;
        else if (beat.en)  par_q <= par_d;
    end

    assign par = par_q;

    // R9
    par_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (par_q == '0));

    // R5
    par_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!beat.en && !clr) |=> $stable(par_q));

endmodule

// File: rtl/rsx_syndrome_bank.sv
module rsx_syndrome_bank
    import rsx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  sym_beat_t beat,
    output symvec_t   syn,
    output logic      nonzero
);
    symvec_t syn_q;

    generate
        for (genvar k = 0; k < NROOTS; k++) begin : g_root
            localparam sym_t STEP = alpha_pow(k);
            always_ff @(posedge clk) begin
                if (rst || clr)    syn_q[k] <= '0;
                else if (beat.en)  syn_q[k] <= gf_mul(syn_q[k], STEP) ^ beat.sym;
            end
        end
    endgenerate

    assign syn     = syn_q;
    assign nonzero = |syn_q;

    // R9
    syn_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> !nonzero);

    // R10
    syn_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!beat.en && !clr) |=> $stable(syn_q));

endmodule

// File: rtl/rsx_parsyn_engine.sv
module rsx_parsyn_engine
    import rsx_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clr_par,
    input  logic                     clr_syn,
    input  logic                     in_valid,
    input  logic                     in_mode,
    input  logic [BYTE_W-1:0]        in_byte,
    output logic [BYTE_W-1:0]        par_byte,
    output logic [NROOTS*SYM_W-1:0]  syn_word,
    output logic                     syn_flag
);
    localparam int WI_W = SEL_W - 1;

    sym_beat_t        enc_beat, chk_beat;
    logic             par_phase;
    logic [SEL_W-1:0] par_sel;
    symvec_t          par_w, syn_w;
    logic [WI_W-1:0]  widx;
    sym_t             cur_word;

    rsx_byte_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr_par || clr_syn),
        .in_valid  (in_valid),
        .mode      (mode_e'(in_mode)),
        .in_byte   (in_byte),
        .enc_beat  (enc_beat),
        .chk_beat  (chk_beat),
        .par_phase (par_phase),
        .par_sel   (par_sel)
    );

    rsx_parity_lfsr u_enc (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr_par),
        .beat (enc_beat),
        .par  (par_w)
    );

    rsx_syndrome_bank u_chk (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr_syn),
        .beat    (chk_beat),
        .syn     (syn_w),
        .nonzero (syn_flag)
    );

    // highest-degree check word leaves first
    assign widx     = WI_W'(NROOTS - 1) - par_sel[SEL_W-1:1];
    assign cur_word = par_w[widx];

    always_comb begin
        if (!par_phase)      par_byte = '0;
        else if (par_sel[0]) par_byte = {{(BYTE_W-PAD_W){1'b0}}, cur_word[SYM_W-1:BYTE_W]};
        else                 par_byte = cur_word[BYTE_W-1:0];
    end

    assign syn_word = syn_w;

    // R3
    par_hi_pad_chk: assert property (@(posedge clk) disable iff (rst)
        (par_phase && par_sel[0]) |-> (par_byte[BYTE_W-1:PAD_W] == '0));

    // R8
    syn_final_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !clr_syn) |=> $stable(syn_word));

endmodule

// File: tb/rsx_parsyn_engine_test.sv
`timescale 1ns/1ps
module rsx_parsyn_engine_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr_par = 1'b0, clr_syn = 1'b0;
    logic        in_valid = 1'b0, in_mode = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic [7:0]  par_byte;
    logic [39:0] syn_word;
    logic        syn_flag;

    rsx_parsyn_engine uut (
        .clk(clk), .rst(rst), .clr_par(clr_par), .clr_syn(clr_syn),
        .in_valid(in_valid), .in_mode(in_mode), .in_byte(in_byte),
        .par_byte(par_byte), .syn_word(syn_word), .syn_flag(syn_flag)
    );

    always #2.5 clk = ~clk;

    int checks = 0, errors = 0;
    bit finished = 0;

    int exp_t [0:1022];
    int log_t [0:1023];
    int gpol  [0:4];
    logic [7:0] mem  [0:519];
    logic [7:0] rxb  [0:519];

    logic [7:0]  par_q [$];
    string       par_tag_q [$];
    logic [40:0] syn_q [$];
    string       syn_tag_q [$];
    logic mon_par = 1'b0, mon_syn = 1'b0;

    function automatic int fmul(int a, int b);
        if (a == 0 || b == 0) return 0;
        return exp_t[(log_t[a] + log_t[b]) % 1023];
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (mon_par) begin
            logic [7:0] e;
            string t;
            e = par_q.pop_front();
            t = par_tag_q.pop_front();
            chk(par_byte == e, t, 64'(par_byte), 64'(e));
        end
        if (mon_syn) begin
            logic [40:0] e;
            string t;
            e = syn_q.pop_front();
            t = syn_tag_q.pop_front();
            chk(syn_word == e[39:0], {t, " syndromes"}, 64'(syn_word), 64'(e[39:0]));
            chk(syn_flag == e[40], {t, " flag R7"}, 64'(syn_flag), 64'(e[40]));
        end
    end

    task automatic strobe(input logic [7:0] b);
        @(posedge clk); #1;
        in_valid = 1'b1; in_byte = b;
    endtask

    task automatic idle(input logic [7:0] junk);
        @(posedge clk); #1;
        in_valid = 1'b0; in_byte = junk; mon_par = 1'b0; mon_syn = 1'b0;
    endtask

    task automatic clear_both();
        @(posedge clk); #1;
        in_valid = 1'b0; clr_par = 1'b1; clr_syn = 1'b1;
        @(posedge clk); #1;
        clr_par = 1'b0; clr_syn = 1'b0;
    endtask

    // R3: bench long division by g(x)
    task automatic write_block(input string tag);
        int w [0:515];
        for (int i = 0; i < 512; i++) w[i] = int'(mem[i]);
        for (int i = 512; i < 516; i++) w[i] = 0;
        for (int i = 0; i < 512; i++) begin
            int c;
            c = w[i];
            for (int j = 1; j <= 4; j++) w[i+j] = w[i+j] ^ fmul(c, gpol[4-j]);
        end
        for (int q = 0; q < 4; q++) begin
            mem[512+2*q]   = w[512+q][7:0];
            mem[512+2*q+1] = {6'b0, w[512+q][9:8]};
        end
        clear_both();
        in_mode = 1'b0;
        for (int i = 0; i < 512; i++) strobe(mem[i]);
        for (int p = 0; p < 8; p++) begin
            par_q.push_back(mem[512+p]);
            par_tag_q.push_back($sformatf("%s R3 R4 R5 parity byte %0d", tag, p));
        end
        for (int p = 0; p < 8; p++) begin
            strobe(8'hC3 ^ 8'(p));
            mon_par = 1'b1;
        end
        idle(8'h00);
    endtask

    // R6: direct power sums over the received symbols
    task automatic read_block(input string tag, input int extra, input bit gaps);
        int r [0:515];
        logic [40:0] e;
        int s;
        for (int i = 0; i < 512; i++) r[i] = int'(rxb[i]);
        for (int q = 0; q < 4; q++) r[512+q] = int'({rxb[513+2*q][1:0], rxb[512+2*q]});
        e = '0;
        for (int k = 0; k < 4; k++) begin
            s = 0;
            for (int j = 0; j < 516; j++)
                if (r[j] != 0) s = s ^ fmul(r[j], exp_t[(k*(515-j)) % 1023]);
            e[10*k +: 10] = 10'(s);
        end
        e[40] = |e[39:0];
        clear_both();
        in_mode = 1'b1;
        for (int i = 0; i < 520; i++) begin
            strobe(rxb[i]);
            if (gaps && (i % 50 == 7)) begin
                idle(8'hFF);
                idle(8'h5A);
            end
        end
        for (int x = 0; x < extra; x++) strobe(8'hE7);
        syn_q.push_back(e);
        syn_tag_q.push_back(tag);
        idle(8'h3C);
        mon_syn = 1'b1;
        @(posedge clk); #1;
        mon_syn = 1'b0;
    endtask

    initial begin
        int v;
        v = 1;
        for (int i = 0; i < 1023; i++) begin
            exp_t[i] = v;
            log_t[v] = i;
            v = v << 1;
            if (v & 1024) v = v ^ 'h409;
        end
        gpol[0] = 1;
        for (int d = 1; d <= 4; d++) gpol[d] = 0;
        for (int j = 0; j < 4; j++)
            for (int d = 4; d >= 0; d--)
                gpol[d] = (d > 0 ? gpol[d-1] : 0) ^ fmul(gpol[d], exp_t[j]);

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(syn_word == 40'h0, "R1 syndromes after reset", 64'(syn_word), 64'h0);
        chk(syn_flag == 1'b0, "R1 flag after reset", 64'(syn_flag), 64'h0);
        chk(par_byte == 8'h00, "R1 par_byte after reset", 64'(par_byte), 64'h0);

        // all-zero data
        for (int i = 0; i < 512; i++) mem[i] = 8'h00;
        write_block("zero block R2");
        for (int i = 0; i < 520; i++) rxb[i] = mem[i];
        read_block("zero block clean R7", 0, 0);

        // patterned data, read back clean with idle gaps (R10)
        for (int i = 0; i < 512; i++) mem[i] = 8'((i * 37 + 5) ^ (i >> 3));
        write_block("ramp block R2");
        @(negedge clk);
        chk(par_byte == 8'h00, "R4 par_byte zero after parity positions", 64'(par_byte), 64'h0);
        for (int i = 0; i < 520; i++) rxb[i] = mem[i];
        read_block("ramp clean with gaps R10", 0, 1);

        // single data error
        for (int i = 0; i < 520; i++) rxb[i] = mem[i];
        rxb[100] = rxb[100] ^ 8'h5A;
        read_block("one data error R6", 0, 0);

        // errors in check-word bytes: low byte and significant high bits
        for (int i = 0; i < 520; i++) rxb[i] = mem[i];
        rxb[514] = rxb[514] ^ 8'h81;
        rxb[517] = rxb[517] ^ 8'h02;
        read_block("parity repack error R6", 0, 0);

        // insignificant high bits and extra strobes
        for (int i = 0; i < 520; i++) rxb[i] = mem[i];
        rxb[513] = rxb[513] ^ 8'hFC;
        rxb[519] = rxb[519] ^ 8'h54;
        read_block("high byte pad R11 with extra strobes R8", 3, 0);

        // two errors, extra strobes after byte 520 ignored
        for (int i = 0; i < 520; i++) rxb[i] = mem[i];
        rxb[0]   = rxb[0] ^ 8'hFF;
        rxb[511] = rxb[511] ^ 8'h01;
        read_block("two errors R6 extra strobes R8", 5, 0);

        // R9: clr_syn zeroes syndromes after a flagged block
        @(posedge clk); #1 clr_syn = 1'b1;
        @(posedge clk); #1 clr_syn = 1'b0;
        @(negedge clk);
        chk(syn_word == 40'h0, "R9 clr_syn syndromes", 64'(syn_word), 64'h0);
        chk(syn_flag == 1'b0, "R9 clr_syn flag", 64'(syn_flag), 64'h0);

        // R9: second write right after a previous one relies on clr_par
        for (int i = 0; i < 512; i++) mem[i] = 8'(255 - i);
        write_block("descending block R9");
        for (int i = 0; i < 520; i++) rxb[i] = mem[i];
        read_block("descending clean R7", 0, 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule